// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive side of a half-duplex synchronous serial link in which it is the clock master. It generates the bit clock on `ck_out`, keeps the shared data line released, samples `dat_in` at the trailing edge of every clock period, and assembles characters least significant bit first. Each finished character drops into a two-entry receive queue. The host reads the oldest unread character from `rd_data` and retires it with `rd_pop`.

Two kinds of reception exist. A one-cycle pulse on `single_req` arms a single-character receive. That request stays pending on `single_busy` and withdraws itself when the character is complete. Holding `cont_en` high makes the clock run without a break. Clearing `cont_en` in the middle of a character stops the clock in the same cycle and throws away the bits gathered so far. If both are active, the single request ends with the first character and reception carries on under `cont_en`.

A character that finishes while the queue is full is lost. In that case a sticky `overrun` flag is raised and the clock is held idle until `ovr_clr` is pulsed.

Top module: `sync_rx_master`

## Requirements
- R1: `dat_drv_en` is 0 whenever `single_busy` or `cont_en` is 1, and 1 otherwise.
- R2: Out of reset, `data_avail`, `overrun` and `single_busy` are 0. Whenever no reception runs, `ck_out` equals `ck_idle_hi`. A pulse on `single_req` or a high `cont_en` starts clock periods.
- R3: With only the single request active, exactly 8 clock periods are generated, and `single_busy` returns to 0 after the eighth sample.
- R4: With `cont_en` held high, clock periods follow one another without a gap until `cont_en` is cleared.
- R5: Clearing `cont_en` while no single request is pending puts `ck_out` at its idle level in the same cycle. The partial character is discarded: nothing is queued, and the next reception starts again from bit 0.
- R6: With both the single request and `cont_en` active, `single_busy` clears after the first character and clock periods continue.
- R7: A clock period lasts 2*(`div_sel`+1) system cycles. The first half is at the active level (the inverse of `ck_idle_hi`). `dat_in` is sampled as `ck_out` returns to idle. The first sampled bit becomes bit 0 of the character.
- R8: The queue holds two characters. `rd_data` shows the oldest unread one, and a pulse on `rd_pop` moves to the next.
- R9: `data_avail` is 1 exactly while at least one unread character is queued.
- R10: A character that completes while two are queued is dropped and sets `overrun`. `overrun` stays set until `ovr_clr` is pulsed. While it is set, `ck_out` stays idle and no clock periods are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 8 | Half-period length minus one, in system cycles |
| ck_idle_hi | input | 1 | Idle level of the generated clock |
| single_req | input | 1 | Pulse that arms a single-character receive |
| cont_en | input | 1 | Level enable for continuous receive |
| rd_pop | input | 1 | Retire the oldest queued character |
| ovr_clr | input | 1 | Clear the overrun flag |
| dat_in | input | 1 | Serial data line |
| ck_out | output | 1 | Generated bit clock |
| dat_drv_en | output | 1 | Data line output driver enable (low while receiving) |
| single_busy | output | 1 | Single-character request pending |
| rd_data | output | 8 | Oldest unread character |
| data_avail | output | 1 | At least one character queued |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that `ck_idle_hi` and `div_sel` change only while no reception runs. They also assume that `rd_pop` is raised only while `data_avail` is high and that `ovr_clr` is a short pulse. The bench changes configuration only between receptions, with the clock idle, and pops only after it has seen `data_avail` set. The slave model in the bench changes `dat_in` only on leading clock edges, so each sample falls half a period after the data was set.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  // Number of system cycles in one half of a bit period
  function automatic int unsigned half_cycles(input int unsigned div);
    return div + 1;
  endfunction

  // Full bit period in system cycles
  function automatic int unsigned bit_period(input int unsigned div);
    return 2 * half_cycles(div);
  endfunction

  // Circular pointer advance for a queue of arbitrary depth
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/sync_rx_baud.sv
module sync_rx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             act_half,
  output logic             trail_evt
);
  logic [DIV_W-1:0] cnt_q;
  logic             half_q;   // 0: active half, 1: idle half
  logic             wrap;

  assign wrap      = (cnt_q == div_sel);
  assign act_half  = run & ~half_q;
  assign trail_evt = run & ~half_q & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      half_q <= ~half_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              trail_evt,
  input  logic              dat_in,
  output logic              char_done,
  output logic [DATA_W-1:0] char_data
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              last_bit;

  assign last_bit  = (bit_q == BIT_W'(DATA_W - 1));
  assign char_done = trail_evt & last_bit;
  // New bit enters at the top, so the first bit ends up in bit 0
  assign char_data = {dat_in, sr_q[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bit_q <= '0;
    end else if (!run) begin
      sr_q  <= '0;
      bit_q <= '0;
    end else if (trail_evt) begin
      sr_q  <= char_data;
      bit_q <= last_bit ? '0 : bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              not_empty
);
  import sync_rx_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign do_push   = push & ~full;
  assign do_pop    = pop & not_empty;
  assign rdata     = mem_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= PTR_W'(ptr_next(int'(wr_q), DEPTH));
      if (do_pop)  rd_q <= PTR_W'(ptr_next(int'(rd_q), DEPTH));
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (do_push && wr_q == PTR_W'(g)) mem_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              ck_idle_hi,
  input  logic              single_req,
  input  logic              cont_en,
  input  logic              rd_pop,
  input  logic              ovr_clr,
  input  logic              dat_in,
  output logic              ck_out,
  output logic              dat_drv_en,
  output logic              single_busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_avail,
  output logic              overrun
);
  logic              single_q, ovr_q;
  logic              run, act_half, trail_evt;
  logic              char_done, fifo_full, push_ok, pop_ok, ovr_evt;
  logic [DATA_W-1:0] char_data;

  // Receive runs under either enable, unless an overrun holds the clock
  assign run        = (single_q | cont_en) & ~ovr_q;
  assign ck_out     = ck_idle_hi ^ act_half;
  assign dat_drv_en = ~(single_q | cont_en);
  assign ovr_evt    = char_done & fifo_full;
  assign push_ok    = char_done & ~fifo_full;
  assign pop_ok     = rd_pop & data_avail;

  assign single_busy = single_q;
  assign overrun     = ovr_q;

  // A new request wins over the self-clear of the previous one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          single_q <= 1'b0;
    else if (single_req) single_q <= 1'b1;
    else if (char_done)  single_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ovr_evt) ovr_q <= 1'b1;
    else if (ovr_clr) ovr_q <= 1'b0;
  end

  sync_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .div_sel   (div_sel),
    .act_half  (act_half),
    .trail_evt (trail_evt)
  );

  sync_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .trail_evt (trail_evt),
    .dat_in    (dat_in),
    .char_done (char_done),
    .char_data (char_data)
  );

  sync_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_ok),
    .wdata     (char_data),
    .pop       (pop_ok),
    .rdata     (rd_data),
    .full      (fifo_full),
    .not_empty (data_avail)
  );
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic ck_idle_hi,
  input logic single_req,
  input logic cont_en,
  input logic ovr_clr,
  input logic ck_out,
  input logic dat_drv_en,
  input logic single_busy,
  input logic data_avail,
  input logic overrun,
  input logic char_done,
  input logic push_ok,
  input logic pop_ok
);
  // R1: line released while any receive enable is active
  a_r1_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (single_busy || cont_en) |-> !dat_drv_en);

  // R3: single request withdraws itself after its character
  a_r3_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !single_req) |=> !single_busy);

  // R5: with no enable, clock idle and no character completes
  a_r5_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_en && !single_busy) |-> (ck_out == ck_idle_hi));
  a_r5_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_en && !single_busy) |-> !char_done);

  // R9: a stored character makes data available
  a_r9_avail: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> data_avail);

  // R10: overrun is sticky and stops the clock
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);
  a_r10_clk_stop: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> (ck_out == ck_idle_hi));
endmodule

bind sync_rx_master sync_rx_master_chk u_chk (.*);

// File: tb/sim_sync_rx_master.sv
`timescale 1ns/1ps
module sim_sync_rx_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_sel = 8'd0;
  logic       ck_idle_hi = 1'b0;
  logic       single_req = 1'b0, cont_en = 1'b0, rd_pop = 1'b0, ovr_clr = 1'b0;
  logic       dat_in = 1'b0;
  logic       ck_out, dat_drv_en, single_busy, data_avail, overrun;
  logic [7:0] rd_data;

  int         n_run = 0, n_fail = 0;
  int         cyc = 0;
  int         bit_i = 0;
  int         lead_prev = 0, lead_last = 0;
  logic [31:0] stream = '0;
  bit         done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  sync_rx_master u0 (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .ck_idle_hi(ck_idle_hi),
    .single_req(single_req), .cont_en(cont_en), .rd_pop(rd_pop), .ovr_clr(ovr_clr),
    .dat_in(dat_in), .ck_out(ck_out), .dat_drv_en(dat_drv_en),
    .single_busy(single_busy), .rd_data(rd_data), .data_avail(data_avail),
    .overrun(overrun)
  );

  // Slave model: presents the next stream bit on every leading clock edge
  logic ck_act;
  assign ck_act = ck_out ^ ck_idle_hi;
  always @(posedge ck_act) begin
    dat_in    = stream[bit_i % 32];
    bit_i     = bit_i + 1;
    lead_prev = lead_last;
    lead_last = cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_single();
    @(negedge clk) single_req = 1'b1;
    @(negedge clk) single_req = 1'b0;
  endtask

  task automatic pop1();
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!single_busy) break;
    end
  endtask

  task automatic wait_bits(input int n);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (bit_i >= n) break;
    end
  endtask

  // {div, idle level, expected byte}
  localparam logic [16:0] VEC [4] = '{
    {8'd0, 1'b0, 8'hA5}, {8'd1, 1'b1, 8'h3C},
    {8'd3, 1'b0, 8'h81}, {8'd2, 1'b1, 8'h7E}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(!data_avail && !overrun && !single_busy, "R2 reset flags", {data_avail, overrun, single_busy}, 0);
    chk(ck_out == 1'b0, "R2 idle low", ck_out, 0);
    chk(dat_drv_en == 1'b1, "R1 drive when idle", dat_drv_en, 1);
    ck_idle_hi = 1'b1;
    #1 chk(ck_out == 1'b1, "R2 idle high", ck_out, 1);

    // Table of single receptions
    foreach (VEC[k]) begin
      div_sel = VEC[k][16:9];
      ck_idle_hi = VEC[k][8];
      stream = {24'h0, VEC[k][7:0]};
      bit_i = 0;
      pulse_single();
      chk(dat_drv_en == 1'b0, "R1 released while receiving", dat_drv_en, 0);
      wait_idle();
      repeat (2 * (int'(div_sel) + 1) + 2) @(negedge clk);
      chk(bit_i == 8, "R3 eight periods", bit_i, 8);
      chk(!single_busy, "R3 self clear", single_busy, 0);
      chk(data_avail, "R9 avail set", data_avail, 1);
      chk(rd_data == VEC[k][7:0], "R7 lsb first sample", rd_data, VEC[k][7:0]);
      pop1();
      chk(!data_avail, "R9 avail clears", data_avail, 0);
    end

    // Both enables, then continuous: two characters
    div_sel = 8'd1; ck_idle_hi = 1'b0;
    stream = 32'h0000_C35A; bit_i = 0;
    @(negedge clk) begin single_req = 1'b1; cont_en = 1'b1; end
    @(negedge clk) single_req = 1'b0;
    wait_idle();
    chk(bit_i == 8, "R6 single ends after first char", bit_i, 8);
    wait_bits(10);
    chk(bit_i >= 9, "R6 clock continues", bit_i, 9);
    chk(lead_last - lead_prev == 4, "R7 period 2*(div+1)", lead_last - lead_prev, 4);
    wait_bits(16);
    @(negedge ck_act);
    @(negedge clk) cont_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(bit_i == 16, "R4 continuous to clear", bit_i, 16);
    chk(rd_data == 8'h5A, "R8 oldest first", rd_data, 8'h5A);
    pop1();
    chk(rd_data == 8'hC3, "R8 second entry", rd_data, 8'hC3);
    pop1();
    chk(!data_avail, "R9 empty", data_avail, 0);

    // Abort mid character
    div_sel = 8'd3; stream = 32'hFFFF_FFFF; bit_i = 0;
    @(negedge clk) cont_en = 1'b1;
    wait_bits(3);
    @(negedge clk) cont_en = 1'b0;
    #1 chk(ck_out == ck_idle_hi, "R5 clock idle at once", ck_out, ck_idle_hi);
    repeat (20) @(negedge clk);
    chk(!data_avail && bit_i == 3, "R5 nothing queued", {data_avail, 8'(bit_i)}, 3);
    stream = 32'h0000_0012; bit_i = 0;
    pulse_single(); wait_idle();
    repeat (10) @(negedge clk);
    chk(rd_data == 8'h12, "R5 restart at bit 0", rd_data, 8'h12);
    pop1();

    // Overrun
    div_sel = 8'd1;
    stream = 32'h0000_0011; bit_i = 0; pulse_single(); wait_idle();
    stream = 32'h0000_0022; bit_i = 0; pulse_single(); wait_idle();
    stream = 32'h0000_0033; bit_i = 0; pulse_single(); wait_idle();
    @(negedge clk);
    chk(overrun, "R10 overrun set", overrun, 1);
    chk(rd_data == 8'h11, "R10 queue intact", rd_data, 8'h11);
    bit_i = 0;
    @(negedge clk) cont_en = 1'b1;
    repeat (50) @(negedge clk);
    chk(bit_i == 0 && overrun, "R10 clock held", bit_i, 0);
    cont_en = 1'b0;
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    chk(!overrun, "R10 cleared", overrun, 0);
    pop1();
    chk(rd_data == 8'h22, "R10 third char dropped", rd_data, 8'h22);
    pop1();
    chk(!data_avail, "R9 drained", data_avail, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule